// File: doc/BRIEF.md
# Three-Port Parallel Interface

This block gives a processor three 8-bit parallel ports, called A, B and C, behind a small register interface. A two-bit address selects one of the three port data registers or the control register. A control write with its top bit set is a mode word. It sets the direction of port A, port B, the upper half of port C and the lower half of port C. It can also put port A or port B into handshake mode. A control write with its top bit clear changes a single port C output bit and leaves the mode unchanged.

Output data is held in latches until the processor writes again or loads a new mode word. Input pins are sampled on every clock edge before the processor can read them. In handshake mode, some port C lines stop being general I/O. They carry a strobe or acknowledge input, a buffer flag output and an interrupt request output for port A or port B. Each output port drives its pins through a per-bit output-enable vector. The pads and the external devices sit outside the block.

Top module: `tri_port_pio`

## Requirements
- R1: Address 00 selects port A, 01 selects port B, 10 selects port C and 11 selects the control register. A read of the control register returns {1, A-handshake, 0, A-input, C-upper-input, B-handshake, B-input, C-lower-input}. A read of a port returns its output latch when the port is an output and its captured input when the port is an input.
- R2: After reset, every port and both halves of port C are simple inputs. The control register reads 8'h9B, every output-enable bit is 0 and every output latch is 0.
- R3: A control write with bit 7 = 1 loads the mode. Bit 6 selects handshake for A, bit 4 makes A an input, bit 3 makes C[7:4] an input, bit 2 selects handshake for B, bit 1 makes B an input and bit 0 makes C[3:0] an input. An output drives all of its output-enable bits to 1. Loading a mode word clears the A, B and C output latches to zero.
- R4: A control write with bit 7 = 0 sets C latch bit wdata[3:1] to wdata[0]. The other latch bits and the mode stay unchanged.
- R5: A port output latch keeps the written value until the next write to that port or the next mode word.
- R6: An input in simple mode is captured on every clock edge. A read returns the pin value from the previous edge.
- R7: Port A handshake input: a rising edge on C[4] latches the A pins and sets the buffer-full flag on C[5]. C[3] (interrupt) equals that flag. A read of port A clears the flag. The latched data is held while the pins change.
- R8: Port A handshake output: a write to port A sets the buffer-full flag on C[7]. A high level on C[6] (acknowledge) clears it. C[3] is the inverse of that flag.
- R9: Port B handshake uses C[2] as strobe (input direction) or acknowledge (output direction), C[1] as the buffer flag and C[0] as the interrupt. The rules are the same as in R7 and R8.
- R10: Port C lines taken by handshake ignore the C latch. Lines that carry a status output always have their output-enable set to 1. Lines that carry a strobe or acknowledge input always have it set to 0. Status lines read back their status value. All other C lines follow the direction of their half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Register access select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects at clock edge) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output value (latch or handshake status) |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench drives mixed-direction mode words with distinct data patterns on every port. Mismatched nibbles in the C readback show whether each half of port C follows its own direction bit. The bit set/reset words reach both the low and the high bit indexes and include a set of a bit that is already 1. These words tell a single-bit update apart from a whole-latch write or a mode reload. The handshake sequences change the pins after a strobe and read back the held value. They also repeat a read while the strobe stays high and assert acknowledge after a write. These steps separate edge capture from level capture and check that each status flag is set and cleared by the right event in both directions.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

    localparam int PW    = 8;
    localparam int IDX_W = $clog2(PW);

    // Handshake pin positions on port C
    localparam int PC_B_INTR = 0;
    localparam int PC_B_FLAG = 1;
    localparam int PC_B_STB  = 2;
    localparam int PC_A_INTR = 3;
    localparam int PC_A_STB  = 4;
    localparam int PC_A_IBF  = 5;
    localparam int PC_A_ACK  = 6;
    localparam int PC_A_OBF  = 7;

    typedef enum logic [1:0] {
        SEL_A   = 2'b00,
        SEL_B   = 2'b01,
        SEL_C   = 2'b10,
        SEL_CTL = 2'b11
    } sel_e;

    typedef struct packed {
        logic a_hs;
        logic a_in;
        logic cu_in;
        logic b_hs;
        logic b_in;
        logic cl_in;
    } mode_t;

    typedef enum logic [1:0] {
        PC_GPIO,
        PC_HS_OUT,
        PC_HS_IN
    } pc_role_e;

    localparam mode_t MODE_RST = '{a_hs: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                   b_hs: 1'b0, b_in: 1'b1, cl_in: 1'b1};

    function automatic mode_t decode_mode(input logic [7:0] w);
        mode_t m;
        m.a_hs  = w[6];
        m.a_in  = w[4];
        m.cu_in = w[3];
        m.b_hs  = w[2];
        m.b_in  = w[1];
        m.cl_in = w[0];
        return m;
    endfunction

    function automatic logic [7:0] encode_mode(input mode_t m);
        return {1'b1, m.a_hs, 1'b0, m.a_in, m.cu_in, m.b_hs, m.b_in, m.cl_in};
    endfunction

    // Role of a port C line under the current mode
    function automatic pc_role_e pc_role(input int idx, input mode_t m);
        pc_role_e r;
        r = PC_GPIO;
        case (idx)
            PC_B_INTR: if (m.b_hs) r = PC_HS_OUT;
            PC_B_FLAG: if (m.b_hs) r = PC_HS_OUT;
            PC_B_STB:  if (m.b_hs) r = PC_HS_IN;
            PC_A_INTR: if (m.a_hs) r = PC_HS_OUT;
            PC_A_STB:  if (m.a_hs && m.a_in)  r = PC_HS_IN;
            PC_A_IBF:  if (m.a_hs && m.a_in)  r = PC_HS_OUT;
            PC_A_ACK:  if (m.a_hs && !m.a_in) r = PC_HS_IN;
            PC_A_OBF:  if (m.a_hs && !m.a_in) r = PC_HS_OUT;
            default:   r = PC_GPIO;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
    import ppi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    output mode_t            mode,
    output logic             mode_load,
    output logic             bsr_en,
    output logic [IDX_W-1:0] bsr_idx,
    output logic             bsr_val,
    output logic [7:0]       ctl_rd
);

    mode_t mode_q;

    assign mode_load = wr_en &  wdata[7];
    assign bsr_en    = wr_en & ~wdata[7];
    assign bsr_idx   = wdata[IDX_W:1];
    assign bsr_val   = wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RST;
        end else if (mode_load) begin
            mode_q <= decode_mode(wdata);
        end
    end

    assign mode   = mode_q;
    assign ctl_rd = encode_mode(mode_q);

    // R4
    bsr_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
        bsr_en |=> $stable(mode_q));

endmodule

// File: rtl/ppi_hport.sv
module ppi_hport
    import ppi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          hs_en,
    input  logic          dir_in,
    input  logic          wr,
    input  logic          rd,
    input  logic [PW-1:0] wdata,
    input  logic [PW-1:0] pin_in,
    input  logic          stb,
    input  logic          ack,
    output logic [PW-1:0] pin_out,
    output logic [PW-1:0] pin_oe,
    output logic [PW-1:0] rd_val,
    output logic          flag,
    output logic          intr
);

    logic [PW-1:0] out_q;
    logic [PW-1:0] in_q;
    logic          stb_q;
    logic          ibf_q;
    logic          obf_q;
    logic          hs_in;
    logic          hs_out;
    logic          stb_rise;

    assign hs_in    = hs_en &  dir_in;
    assign hs_out   = hs_en & ~dir_in;
    assign stb_rise = stb & ~stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            in_q  <= '0;
            stb_q <= 1'b0;
            ibf_q <= 1'b0;
            obf_q <= 1'b0;
        end else begin
            stb_q <= stb;

            if (clear)   out_q <= '0;
            else if (wr) out_q <= wdata;

            if (!hs_in || stb_rise) in_q <= pin_in;

            if (clear)                 ibf_q <= 1'b0;
            else if (hs_in && stb_rise) ibf_q <= 1'b1;
            else if (rd)               ibf_q <= 1'b0;

            if (clear)            obf_q <= 1'b0;
            else if (hs_out && wr) obf_q <= 1'b1;
            else if (ack)         obf_q <= 1'b0;
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = {PW{~dir_in}};
    assign rd_val  = dir_in ? in_q : out_q;
    assign flag    = dir_in ? ibf_q : obf_q;
    assign intr    = hs_en & (dir_in ? ibf_q : ~obf_q);

    // R8
    obf_set_chk: assert property (@(posedge clk) disable iff (rst)
        hs_out && wr && !clear |=> flag);

    // R7
    ibf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        hs_in && rd && !stb_rise && !clear |=> !flag);

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr && !clear |=> $stable(pin_out));

endmodule

// File: rtl/ppi_portc.sv
module ppi_portc
    import ppi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             wr,
    input  logic [PW-1:0]    wdata,
    input  logic             bsr_en,
    input  logic [IDX_W-1:0] bsr_idx,
    input  logic             bsr_val,
    input  mode_t            mode,
    input  logic [PW-1:0]    pin_in,
    input  logic             a_flag,
    input  logic             a_intr,
    input  logic             b_flag,
    input  logic             b_intr,
    output logic [PW-1:0]    pin_out,
    output logic [PW-1:0]    pin_oe,
    output logic [PW-1:0]    rd_val
);

    logic [PW-1:0] lat_q;
    logic [PW-1:0] cap_q;
    logic [PW-1:0] stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            cap_q <= '0;
        end else begin
            cap_q <= pin_in;
            if (clear)       lat_q <= '0;
            else if (wr)     lat_q <= wdata;
            else if (bsr_en) lat_q[bsr_idx] <= bsr_val;
        end
    end

    always_comb begin
        stat            = '0;
        stat[PC_B_INTR] = b_intr;
        stat[PC_B_FLAG] = b_flag;
        stat[PC_A_INTR] = a_intr;
        stat[PC_A_IBF]  = a_flag;
        stat[PC_A_OBF]  = a_flag;
    end

    for (genvar gi = 0; gi < PW; gi++) begin : g_line
        pc_role_e role;
        logic     grp_in;
        logic     o_bit;
        logic     e_bit;
        logic     r_bit;

        assign role   = pc_role(gi, mode);
        assign grp_in = (gi >= PW / 2) ? mode.cu_in : mode.cl_in;

        always_comb begin
            case (role)
                PC_HS_OUT: begin
                    o_bit = stat[gi];
                    e_bit = 1'b1;
                    r_bit = stat[gi];
                end
                PC_HS_IN: begin
                    o_bit = lat_q[gi];
                    e_bit = 1'b0;
                    r_bit = cap_q[gi];
                end
                default: begin
                    o_bit = lat_q[gi];
                    e_bit = ~grp_in;
                    r_bit = grp_in ? cap_q[gi] : lat_q[gi];
                end
            endcase
        end

        assign pin_out[gi] = o_bit;
        assign pin_oe[gi]  = e_bit;
        assign rd_val[gi]  = r_bit;
    end

    // R4
    bsr_bit_chk: assert property (@(posedge clk) disable iff (rst)
        bsr_en && !wr && !clear |=> lat_q[$past(bsr_idx)] == $past(bsr_val));

endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
    import ppi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] pa_in,
    output logic [7:0] pa_out,
    output logic [7:0] pa_oe,
    input  logic [7:0] pb_in,
    output logic [7:0] pb_out,
    output logic [7:0] pb_oe,
    input  logic [7:0] pc_in,
    output logic [7:0] pc_out,
    output logic [7:0] pc_oe
);

    sel_e             sel;
    mode_t            mode;
    logic             mode_load;
    logic             bsr_en;
    logic [IDX_W-1:0] bsr_idx;
    logic             bsr_val;
    logic [7:0]       ctl_rd;
    logic [PW-1:0]    a_rd;
    logic [PW-1:0]    b_rd;
    logic [PW-1:0]    c_rd;
    logic             a_flag;
    logic             a_intr;
    logic             b_flag;
    logic             b_intr;

    assign sel = sel_e'(addr);

    ppi_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cs && wr_en && sel == SEL_CTL),
        .wdata     (wdata),
        .mode      (mode),
        .mode_load (mode_load),
        .bsr_en    (bsr_en),
        .bsr_idx   (bsr_idx),
        .bsr_val   (bsr_val),
        .ctl_rd    (ctl_rd)
    );

    ppi_hport u_port_a (
        .clk     (clk),
        .rst     (rst),
        .clear   (mode_load),
        .hs_en   (mode.a_hs),
        .dir_in  (mode.a_in),
        .wr      (cs && wr_en && sel == SEL_A),
        .rd      (cs && rd_en && sel == SEL_A),
        .wdata   (wdata),
        .pin_in  (pa_in),
        .stb     (pc_in[PC_A_STB]),
        .ack     (pc_in[PC_A_ACK]),
        .pin_out (pa_out),
        .pin_oe  (pa_oe),
        .rd_val  (a_rd),
        .flag    (a_flag),
        .intr    (a_intr)
    );

    ppi_hport u_port_b (
        .clk     (clk),
        .rst     (rst),
        .clear   (mode_load),
        .hs_en   (mode.b_hs),
        .dir_in  (mode.b_in),
        .wr      (cs && wr_en && sel == SEL_B),
        .rd      (cs && rd_en && sel == SEL_B),
        .wdata   (wdata),
        .pin_in  (pb_in),
        .stb     (pc_in[PC_B_STB]),
        .ack     (pc_in[PC_B_STB]),
        .pin_out (pb_out),
        .pin_oe  (pb_oe),
        .rd_val  (b_rd),
        .flag    (b_flag),
        .intr    (b_intr)
    );

    ppi_portc u_port_c (
        .clk     (clk),
        .rst     (rst),
        .clear   (mode_load),
        .wr      (cs && wr_en && sel == SEL_C),
        .wdata   (wdata),
        .bsr_en  (bsr_en),
        .bsr_idx (bsr_idx),
        .bsr_val (bsr_val),
        .mode    (mode),
        .pin_in  (pc_in),
        .a_flag  (a_flag),
        .a_intr  (a_intr),
        .b_flag  (b_flag),
        .b_intr  (b_intr),
        .pin_out (pc_out),
        .pin_oe  (pc_oe),
        .rd_val  (c_rd)
    );

    always_comb begin
        unique case (sel)
            SEL_A:   rdata = a_rd;
            SEL_B:   rdata = b_rd;
            SEL_C:   rdata = c_rd;
            default: rdata = ctl_rd;
        endcase
    end

    // R3
    mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mode_load |=> (pa_out == '0) && (pb_out == '0));

endmodule

// File: tb/tri_port_pio_bench.sv
module tri_port_pio_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs;
    logic       wr_en;
    logic       rd_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [7:0] pa_in, pa_out, pa_oe;
    logic [7:0] pb_in, pb_out, pb_oe;
    logic [7:0] pc_in, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       sample_ev;

    always #4 clk = ~clk;

    tri_port_pio u_tri_port_pio (
        .clk    (clk),
        .rst    (rst),
        .cs     (cs),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .pa_in  (pa_in),
        .pa_out (pa_out),
        .pa_oe  (pa_oe),
        .pb_in  (pb_in),
        .pb_out (pb_out),
        .pb_oe  (pb_oe),
        .pc_in  (pc_in),
        .pc_out (pc_out),
        .pc_oe  (pc_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected read item and compares with the bus
    always @(sample_ev) begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0;
    endtask

    task automatic read_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        cs = 1'b1; rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #2;
        ->sample_ev;
        @(negedge clk);
        cs = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cs = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        addr = 2'b00; wdata = 8'h00;
        pa_in = 8'h00; pb_in = 8'h00; pc_in = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        #1;
        chk("R2 pa_oe", pa_oe, 8'h00);
        chk("R2 pb_oe", pb_oe, 8'h00);
        chk("R2 pc_oe", pc_oe, 8'h00);
        chk("R2 pa_out", pa_out, 8'h00);
        read_exp(2'b11, 8'h9B, "R2 control after reset");

        // R6 simple input capture
        pa_in = 8'h3C; pb_in = 8'hA5; pc_in = 8'h5A;
        read_exp(2'b00, 8'h3C, "R6 port A input");
        read_exp(2'b01, 8'hA5, "R6 port B input");
        read_exp(2'b10, 8'h5A, "R6 port C input");

        // R3 mixed directions: A out, B in, C upper in, C lower out
        write_reg(2'b11, 8'h8A);
        #1;
        chk("R3 pa_oe", pa_oe, 8'hFF);
        chk("R3 pb_oe", pb_oe, 8'h00);
        chk("R3 pc_oe", pc_oe, 8'h0F);
        read_exp(2'b11, 8'h8A, "R1 control readback");

        // R1 / R5 latches and readback
        write_reg(2'b00, 8'h5E);
        #1;
        chk("R5 pa_out after write", pa_out, 8'h5E);
        read_exp(2'b00, 8'h5E, "R1 port A output readback");
        write_reg(2'b01, 8'h77);
        read_exp(2'b01, 8'hA5, "R1 port B input readback");
        write_reg(2'b10, 8'h96);
        #1;
        chk("R10 pc_out gpio", pc_out, 8'h96);
        read_exp(2'b10, 8'h56, "R10 port C split readback");
        repeat (5) @(negedge clk);
        #1;
        chk("R5 pa_out held", pa_out, 8'h5E);

        // R4 bit set/reset
        write_reg(2'b11, 8'h01);
        #1;
        chk("R4 set bit0", pc_out, 8'h97);
        write_reg(2'b11, 8'h04);
        #1;
        chk("R4 clear bit2", pc_out, 8'h93);
        read_exp(2'b11, 8'h8A, "R4 mode unchanged");
        write_reg(2'b11, 8'h0F);
        #1;
        chk("R4 set bit7 already set", pc_out, 8'h93);
        write_reg(2'b11, 8'h0E);
        #1;
        chk("R4 clear bit7", pc_out, 8'h13);
        read_exp(2'b10, 8'h53, "R4 port C after bit ops");

        // R3 mode reload clears latches
        write_reg(2'b11, 8'h8A);
        #1;
        chk("R3 pa_out cleared", pa_out, 8'h00);
        chk("R3 pc_out cleared", pc_out, 8'h00);

        // R7 port A handshake input
        pc_in = 8'h00;
        write_reg(2'b11, 8'hD0);
        #1;
        chk("R10 pc_oe A hs in", pc_oe, 8'hEF);
        chk("R7 ibf low after mode", {6'b0, pc_out[5], pc_out[3]}, 8'h00);
        pa_in = 8'h42;
        @(negedge clk);
        pc_in = 8'h10;
        @(negedge clk);
        pa_in = 8'h99;
        @(negedge clk);
        #1;
        chk("R7 ibf and intr set", {6'b0, pc_out[5], pc_out[3]}, 8'h03);
        read_exp(2'b00, 8'h42, "R7 strobed data held");
        #1;
        chk("R7 ibf cleared by read", {6'b0, pc_out[5], pc_out[3]}, 8'h00);
        read_exp(2'b00, 8'h42, "R7 no relatch on level");
        write_reg(2'b10, 8'hFF);
        #1;
        chk("R10 status ignores latch", {6'b0, pc_out[7], pc_out[5]}, 8'h02);
        read_exp(2'b10, 8'hD7, "R10 port C readback in A hs");

        // R8 port A handshake output
        pc_in = 8'h00;
        write_reg(2'b11, 8'hC0);
        #1;
        chk("R10 pc_oe A hs out", pc_oe, 8'hBF);
        chk("R8 obf low intr high", {6'b0, pc_out[7], pc_out[3]}, 8'h01);
        write_reg(2'b00, 8'h3A);
        #1;
        chk("R8 pa_out", pa_out, 8'h3A);
        chk("R8 obf set", {6'b0, pc_out[7], pc_out[3]}, 8'h02);
        pc_in = 8'h40;
        @(negedge clk);
        #1;
        chk("R8 ack clears obf", {6'b0, pc_out[7], pc_out[3]}, 8'h01);
        pc_in = 8'h00;

        // R9 port B handshake input
        write_reg(2'b11, 8'h86);
        #1;
        chk("R9 pc_oe B hs in", pc_oe, 8'hFB);
        pb_in = 8'h6D;
        @(negedge clk);
        pc_in = 8'h04;
        @(negedge clk);
        pb_in = 8'h00;
        @(negedge clk);
        #1;
        chk("R9 B flag and intr set", {6'b0, pc_out[1], pc_out[0]}, 8'h03);
        read_exp(2'b01, 8'h6D, "R9 B strobed data");
        #1;
        chk("R9 B flag cleared", {6'b0, pc_out[1], pc_out[0]}, 8'h00);

        // R9 port B handshake output
        pc_in = 8'h00;
        write_reg(2'b11, 8'h84);
        #1;
        chk("R9 B obf low intr high", {6'b0, pc_out[1], pc_out[0]}, 8'h01);
        write_reg(2'b01, 8'hE1);
        #1;
        chk("R9 pb_out", pb_out, 8'hE1);
        chk("R9 pb_oe", pb_oe, 8'hFF);
        chk("R9 B obf set", {6'b0, pc_out[1], pc_out[0]}, 8'h02);
        pc_in = 8'h04;
        @(negedge clk);
        #1;
        chk("R9 B ack clears obf", {6'b0, pc_out[1], pc_out[0]}, 8'h01);
        read_exp(2'b11, 8'h84, "R1 control final");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule